// File: doc/BRIEF.md
# Next Program Counter Selector

This block holds the program counter of a single-cycle processor and computes, on every clock, the address of the next instruction. From the current PC, the instruction word and the first register read operand it forms seven candidates: the sequential address, a relative branch target, an absolute jump target, a register jump target and three fixed vectors (reset, illegal instruction, interrupt). A 3-bit select code from the control decoder picks one candidate, and the PC register loads it at the clock edge.

The PC is a registered output. A synchronous active-high reset loads the reset vector no matter what the select code is. Branch condition evaluation, instruction fetch and the register file are outside the block. The control logic decides whether a branch is taken and drives the select code to match.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` becomes 0x80000000 at that edge, whatever `pc_sel` is.
- R2: With `pc_sel` = 0, the next `pc` is the current `pc` plus 4, modulo 2^32.
- R3: With `pc_sel` = 1, the next `pc` is `pc` + 4 + (sign-extended `instr[15:0]` × 4). Bit 15 of the immediate is the sign.
- R4: With `pc_sel` = 2, the next `pc` is {(`pc`+4)[31:28], `instr[25:0]`, 2'b00}.
- R5: With `pc_sel` = 3, the next `pc` equals `rs_val`, all 32 bits taken unchanged.
- R6: With `pc_sel` = 4, the next `pc` is 0x80000000.
- R7: With `pc_sel` = 5, the next `pc` is 0x80000040, the illegal instruction vector.
- R8: With `pc_sel` = 6, the next `pc` is 0x80000080, the interrupt vector.
- R9: The code `pc_sel` = 7 behaves exactly like code 0 (next `pc` = `pc` + 4).
- R10: `pc_plus4` always shows the current `pc` plus 4, combinationally, so the decoder can use it as a link address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_sel | input | 3 | Next-PC source code (0..7) |
| instr | input | 32 | Current instruction word |
| rs_val | input | 32 | First register read operand |
| pc | output | 32 | Registered program counter |
| pc_plus4 | output | 32 | Current PC plus 4 |

## Verification
Two situations are hard to reach from the ports: the PC wrapping past 0xFFFFFFFC, and a jump that carries a segment change in the top four bits. The stimulus loads 0xFFFFFFF8 and then 0x0FFFFFFC through the register jump code. From those values, sequential steps and jumps cross the wrap and the 0x0/0x1 segment boundary. Large negative and positive branch offsets follow, so carries run through the whole adder.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    SEL_SEQ    = 3'd0,
    SEL_BRANCH = 3'd1,
    SEL_JUMP   = 3'd2,
    SEL_REG    = 3'd3,
    SEL_RESET  = 3'd4,
    SEL_ILLOP  = 3'd5,
    SEL_IRQ    = 3'd6,
    SEL_SPARE  = 3'd7
  } npc_sel_e;
endpackage

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int XLEN    = 32,
  parameter int IMM_W   = 16,
  parameter int JFLD_W  = 26,
  parameter int ALIGN_W = 2
) (
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] insn,
  output logic [XLEN-1:0] seq_addr,
  output logic [XLEN-1:0] br_addr,
  output logic [XLEN-1:0] jmp_addr
);
  localparam int SEG_W = XLEN - JFLD_W - ALIGN_W;
  localparam int EXT_W = XLEN - IMM_W - ALIGN_W;

  logic [XLEN-1:0] offset;

  always_comb begin
    seq_addr = cur_pc + XLEN'(4);
    offset   = {{EXT_W{insn[IMM_W-1]}}, insn[IMM_W-1:0], {ALIGN_W{1'b0}}};
    br_addr  = seq_addr + offset;
    jmp_addr = {seq_addr[XLEN-1 -: SEG_W], insn[JFLD_W-1:0], {ALIGN_W{1'b0}}};
  end
endmodule

// File: rtl/npc_mux.sv
module npc_mux
  import npc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter logic [31:0] VEC_RESET = 32'h8000_0000,
  parameter logic [31:0] VEC_ILLOP = 32'h8000_0040,
  parameter logic [31:0] VEC_IRQ   = 32'h8000_0080
) (
  input  logic [2:0]      sel,
  input  logic [XLEN-1:0] seq_addr,
  input  logic [XLEN-1:0] br_addr,
  input  logic [XLEN-1:0] jmp_addr,
  input  logic [XLEN-1:0] reg_addr,
  output logic [XLEN-1:0] next_addr
);
  always_comb begin
    unique case (npc_sel_e'(sel))
      SEL_BRANCH: next_addr = br_addr;
      SEL_JUMP:   next_addr = jmp_addr;
      SEL_REG:    next_addr = reg_addr;
      SEL_RESET:  next_addr = XLEN'(VEC_RESET);
      SEL_ILLOP:  next_addr = XLEN'(VEC_ILLOP);
      SEL_IRQ:    next_addr = XLEN'(VEC_IRQ);
      default:    next_addr = seq_addr;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int          XLEN      = 32,
  parameter logic [31:0] VEC_RESET = 32'h8000_0000,
  parameter logic [31:0] VEC_ILLOP = 32'h8000_0040,
  parameter logic [31:0] VEC_IRQ   = 32'h8000_0080
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      pc_sel,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] rs_val,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] pc_plus4
);
  logic [XLEN-1:0] seq_a, br_a, jmp_a, nxt_a;

  npc_targets #(.XLEN(XLEN)) u_tgt (
    .cur_pc(pc), .insn(instr),
    .seq_addr(seq_a), .br_addr(br_a), .jmp_addr(jmp_a)
  );

  npc_mux #(.XLEN(XLEN), .VEC_RESET(VEC_RESET), .VEC_ILLOP(VEC_ILLOP),
            .VEC_IRQ(VEC_IRQ)) u_mux (
    .sel(pc_sel), .seq_addr(seq_a), .br_addr(br_a), .jmp_addr(jmp_a),
    .reg_addr(rs_val), .next_addr(nxt_a)
  );

  always_ff @(posedge clk) begin
    if (rst) pc <= XLEN'(VEC_RESET);
    else     pc <= nxt_a;
  end

  assign pc_plus4 = seq_a;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      pc_sel,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] pc_plus4
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  assert_reset_vec_R1: assert property (@(posedge clk)
    armed && rst |=> pc == 32'h8000_0000);
  assert_seq_R2: assert property (@(posedge clk) disable iff (rst)
    armed && pc_sel == 3'd0 |=> pc == $past(pc) + 32'd4);
  assert_regjmp_R5: assert property (@(posedge clk) disable iff (rst)
    armed && pc_sel == 3'd3 |=> pc == $past(rs_val));
  assert_illop_R7: assert property (@(posedge clk) disable iff (rst)
    armed && pc_sel == 3'd5 |=> pc == 32'h8000_0040);
  assert_irq_R8: assert property (@(posedge clk) disable iff (rst)
    armed && pc_sel == 3'd6 |=> pc == 32'h8000_0080);
  assert_spare_R9: assert property (@(posedge clk) disable iff (rst)
    armed && pc_sel == 3'd7 |=> pc == $past(pc) + 32'd4);
  assert_link_R10: assert property (@(posedge clk)
    armed |-> pc_plus4 == pc + 32'd4);
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  pc_sel = 3'd0;
  logic [31:0] instr = 32'd0;
  logic [31:0] rs_val = 32'd0;
  logic [31:0] pc, pc_plus4;

  int total = 0, bad = 0;
  logic [31:0] model_pc = 32'h8000_0000;

  always #10 clk = ~clk;

  npc_unit dut (.*);

  function automatic logic [31:0] ref_next(input logic [31:0] p, input logic [2:0] s,
                                           input logic [31:0] ins, input logic [31:0] r);
    logic [31:0] p4;
    p4 = p + 32'd4;
    case (s)
      3'd1: return p4 + 32'($signed(ins[15:0])) * 32'd4;
      3'd2: return {p4[31:28], ins[25:0], 2'b00};
      3'd3: return r;
      3'd4: return 32'h8000_0000;
      3'd5: return 32'h8000_0040;
      3'd6: return 32'h8000_0080;
      default: return p4;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic r, input logic [2:0] s,
                      input logic [31:0] ins, input logic [31:0] rv);
    rst = r; pc_sel = s; instr = ins; rs_val = rv;
    @(posedge clk);
    model_pc = r ? 32'h8000_0000 : ref_next(model_pc, s, ins, rv);
    #5;
    check(req, pc, model_pc);
    check("R10", pc_plus4, model_pc + 32'd4);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(posedge clk); #5;
    step("R1", 1'b1, 3'd3, 32'd0, 32'h1234_5678);
    check("R1", pc, 32'h8000_0000);
    step("R2", 1'b0, 3'd0, 32'd0, 32'd0);
    check("R2", pc, 32'h8000_0004);
    step("R2", 1'b0, 3'd0, 32'hFFFF_FFFF, 32'd0);
    step("R3", 1'b0, 3'd1, 32'h0000_0010, 32'd0);
    check("R3", pc, 32'h8000_004C);
    step("R3", 1'b0, 3'd1, 32'h0000_FFFF, 32'd0);
    check("R3", pc, 32'h8000_004C);
    step("R3", 1'b0, 3'd1, 32'h0000_8000, 32'd0);
    step("R3", 1'b0, 3'd1, 32'h0000_7FFF, 32'd0);
    step("R4", 1'b0, 3'd2, 32'hFFFF_FFFF, 32'd0);
    check("R4", pc, 32'h8FFF_FFFC);
    step("R5", 1'b0, 3'd3, 32'd0, 32'hFFFF_FFF8);
    check("R5", pc, 32'hFFFF_FFF8);
    step("R2", 1'b0, 3'd0, 32'd0, 32'd0);
    step("R2", 1'b0, 3'd0, 32'd0, 32'd0);
    check("R2", pc, 32'h0000_0000);
    step("R5", 1'b0, 3'd3, 32'd0, 32'h0FFF_FFFC);
    step("R4", 1'b0, 3'd2, 32'h0000_0001, 32'd0);
    check("R4", pc, 32'h1000_0004);
    step("R7", 1'b0, 3'd5, 32'd0, 32'd0);
    check("R7", pc, 32'h8000_0040);
    step("R8", 1'b0, 3'd6, 32'd0, 32'd0);
    check("R8", pc, 32'h8000_0080);
    step("R9", 1'b0, 3'd7, 32'hABCD_1234, 32'h5555_5555);
    check("R9", pc, 32'h8000_0084);
    step("R6", 1'b0, 3'd4, 32'd0, 32'd0);
    check("R6", pc, 32'h8000_0000);
    step("R5", 1'b0, 3'd3, 32'd0, 32'h0000_1000);
    step("R1", 1'b1, 3'd6, 32'd0, 32'd0);
    check("R1", pc, 32'h8000_0000);
    for (int i = 0; i < 200; i++) begin
      logic [2:0] s;
      s = 3'($urandom_range(0, 7));
      step("R2", 1'b0, s, $urandom, $urandom & 32'hFFFF_FFFC);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule